// File: doc/BRIEF.md
# Word-Access Byte FIFO with Thresholds

This block is a 128-byte buffer that sits between a register port and a byte-wide serial engine. Software moves whole 32-bit words in or out through a single data port. The engine pushes or pops one byte at a time. The oldest byte always occupies bits 7:0 of a word. The buffer keeps byte-granular counts of the filled space and the free space. It can be used in either direction: software fills it with words for the engine to send, or the engine fills it with received bytes for software to collect.

Two programmable thresholds raise interrupt requests in the middle of a transfer. The write-threshold source means there is room to refill. The read-threshold source means there is data to drain. Two more sources flag a word access that the buffer refused. Every source is a sticky status bit that is cleared by writing 1. A per-source enable gates each bit onto a single interrupt line. Once the engine reports the end of a transfer, software can read a last partial word of 1 to 3 bytes, with its upper bytes returned as zero.

Top module: `wordbyte_fifo`

## Requirements
- R1: While reset is asserted, the filled count is 0, the free count is 128, all status bits are 0 and the interrupt line is low.
- R2: The filled count equals the number of bytes held, and the filled count plus the free count always equals 128.
- R3: A word write stores 4 bytes, least-significant byte first. The engine read byte always shows the oldest byte, and an engine pop removes it.
- R4: Bytes pushed by the engine appear in the software read word with the oldest byte in bits 7:0. A software read removes 4 bytes.
- R5: A word write while fewer than 4 bytes are free is ignored and sets the overflow status bit (bit 2).
- R6: A word read is ignored and sets the underflow status bit (bit 3) when either of these holds: fewer than 4 bytes are filled and end-of-transfer is low, or the buffer is empty.
- R7: While end-of-transfer is high and 1 to 3 bytes are filled, the read word carries those bytes with its upper bytes zero, and a read empties the buffer.
- R8: Write-threshold status (bit 0) is set on the clock edge that ends any cycle whose filled count is at or below the write threshold.
- R9: Read-threshold status (bit 1) is set on the clock edge that ends any cycle whose filled count is at or above the read threshold.
- R10: Status bits are sticky and clear only when 1 is written to them. If a bit is cleared in the same cycle that its condition holds, the bit stays set.
- R11: The interrupt line is the OR over all bits of status AND enable.
- R12: A software write request in a cycle drops any engine push in that cycle, and a software read request drops any engine pop. An engine push while full and an engine pop while empty are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_wr_i | input | 1 | Word write strobe |
| sw_wdata_i | input | 32 | Word to write |
| sw_rd_i | input | 1 | Word read strobe (pops the word shown on sw_rdata_o) |
| sw_rdata_o | output | 32 | Oldest bytes as a word, unfilled lanes zero |
| eng_push_i | input | 1 | Engine byte push |
| eng_wdata_i | input | 8 | Byte pushed by the engine |
| eng_pop_i | input | 1 | Engine byte pop |
| eng_rdata_o | output | 8 | Oldest byte |
| eng_done_i | input | 1 | End of transfer, allows a partial last word |
| thr_wr_i | input | 8 | Write threshold in bytes |
| thr_rd_i | input | 8 | Read threshold in bytes |
| irq_en_i | input | 4 | Per-source enable: 0 write thr, 1 read thr, 2 overflow, 3 underflow |
| irq_clr_i | input | 4 | Write-1-to-clear pulses for the status bits |
| fill_o | output | 8 | Bytes filled |
| free_o | output | 8 | Bytes free |
| irq_stat_o | output | 4 | Sticky status bits |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 128 bytes deep and 4-byte words. At this depth a fill of 32 words reaches the full boundary, so the overflow refusal and the drop of an engine push while full are both exercised. Random traffic wraps the byte pointers many times, and pushes from the engine leave words that straddle the wrap point. The engine pushes a byte count that is not a multiple of four, which brings the 1-to-3-byte partial word and its padding within reach.

// File: rtl/wbf_pkg.sv
package wbf_pkg;
  localparam int unsigned IRQ_N    = 4;
  localparam int unsigned IRQ_WTHR = 0;
  localparam int unsigned IRQ_RTHR = 1;
  localparam int unsigned IRQ_OVF  = 2;
  localparam int unsigned IRQ_UDF  = 3;

  typedef struct packed {
    logic udf;
    logic ovf;
    logic rthr;
    logic wthr;
  } irq_vec_t;
endpackage

// File: rtl/wbf_ctrl.sv
module wbf_ctrl #(
  parameter int unsigned DEPTH_BYTES = 128,
  parameter int unsigned WORD_BYTES  = 4,
  parameter int unsigned CNT_W       = $clog2(DEPTH_BYTES + 1),
  parameter int unsigned PTR_W       = $clog2(DEPTH_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_wr_i,
  input  logic             sw_rd_i,
  input  logic             eng_push_i,
  input  logic             eng_pop_i,
  input  logic             eng_done_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [PTR_W-1:0] wp_o,
  output logic [PTR_W-1:0] rp_o,
  output logic             wr_word_o,
  output logic             wr_byte_o,
  output logic             ovf_o,
  output logic             udf_o
);
  localparam logic [CNT_W-1:0] WB_C    = CNT_W'(WORD_BYTES);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH_BYTES);

  logic [CNT_W-1:0] cnt_q, free, add, sub, rd_n;
  logic [PTR_W-1:0] wp_q, rp_q;
  logic wr_ok, rd_ok, rd_full, rd_part, push_ok, pop_ok;

  assign free    = DEPTH_C - cnt_q;
  assign wr_ok   = sw_wr_i && (free >= WB_C);
  assign rd_full = cnt_q >= WB_C;
  assign rd_part = eng_done_i && (cnt_q != '0);
  assign rd_ok   = sw_rd_i && (rd_full || rd_part);
  assign rd_n    = rd_full ? WB_C : cnt_q;
  // software requests take the cycle; engine access of the same direction drops
  assign push_ok = eng_push_i && !sw_wr_i && (cnt_q != DEPTH_C);
  assign pop_ok  = eng_pop_i && !sw_rd_i && (cnt_q != '0);

  assign add = wr_ok ? WB_C : CNT_W'(push_ok);
  assign sub = rd_ok ? rd_n : CNT_W'(pop_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
    end else begin
      cnt_q <= cnt_q + add - sub;
      wp_q  <= wp_q + add[PTR_W-1:0];
      rp_q  <= rp_q + sub[PTR_W-1:0];
    end
  end

  assign cnt_o     = cnt_q;
  assign wp_o      = wp_q;
  assign rp_o      = rp_q;
  assign wr_word_o = wr_ok;
  assign wr_byte_o = push_ok;
  assign ovf_o     = sw_wr_i && !wr_ok;
  assign udf_o     = sw_rd_i && !rd_ok;

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DEPTH_C);
  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_wr_i && free < WB_C && !sw_rd_i && !eng_pop_i) |=> $stable(cnt_q));
  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_rd_i && cnt_q == '0 && !sw_wr_i && !eng_push_i) |=> cnt_q == '0);
  p_push_drop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_wr_i && eng_push_i && free >= WB_C && !sw_rd_i && !eng_pop_i)
      |=> cnt_q == $past(cnt_q) + WB_C);
endmodule

// File: rtl/wbf_store.sv
module wbf_store #(
  parameter int unsigned DEPTH_BYTES = 128,
  parameter int unsigned WORD_BYTES  = 4,
  parameter int unsigned CNT_W       = $clog2(DEPTH_BYTES + 1),
  parameter int unsigned PTR_W       = $clog2(DEPTH_BYTES),
  parameter int unsigned WORD_W      = 8 * WORD_BYTES
) (
  input  logic              clk_i,
  input  logic              wr_word_i,
  input  logic              wr_byte_i,
  input  logic [PTR_W-1:0]  wp_i,
  input  logic [PTR_W-1:0]  rp_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [7:0]        byte_i,
  output logic [WORD_W-1:0] word_o,
  output logic [7:0]        byte_o
);
  logic [7:0] mem_q [DEPTH_BYTES];

  always_ff @(posedge clk_i) begin
    if (wr_word_i) begin
      for (int i = 0; i < int'(WORD_BYTES); i++)
        mem_q[wp_i + PTR_W'(i)] <= word_i[8*i +: 8];
    end else if (wr_byte_i) begin
      mem_q[wp_i] <= byte_i;
    end
  end

  // lanes past the filled count read as zero
  for (genvar g = 0; g < int'(WORD_BYTES); g++) begin : g_lane
    assign word_o[8*g +: 8] = (CNT_W'(g) < cnt_i) ? mem_q[rp_i + PTR_W'(g)] : 8'h00;
  end

  assign byte_o = mem_q[rp_i];
endmodule

// File: rtl/wbf_irq.sv
module wbf_irq
  import wbf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  irq_vec_t         set_i,
  input  logic [IRQ_N-1:0] clr_i,
  input  logic [IRQ_N-1:0] en_i,
  output logic [IRQ_N-1:0] stat_o,
  output logic             irq_o
);
  logic [IRQ_N-1:0] stat_q;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | set_i;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & en_i);

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i)));
  p_ovf_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i.ovf |=> stat_q[IRQ_OVF]);
  p_udf_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i.udf |=> stat_q[IRQ_UDF]);
endmodule

// File: rtl/wordbyte_fifo.sv
module wordbyte_fifo
  import wbf_pkg::*;
#(
  parameter int unsigned DEPTH_BYTES = 128,
  parameter int unsigned WORD_BYTES  = 4,
  parameter int unsigned CNT_W       = $clog2(DEPTH_BYTES + 1),
  parameter int unsigned WORD_W      = 8 * WORD_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_wr_i,
  input  logic [WORD_W-1:0] sw_wdata_i,
  input  logic              sw_rd_i,
  output logic [WORD_W-1:0] sw_rdata_o,
  input  logic              eng_push_i,
  input  logic [7:0]        eng_wdata_i,
  input  logic              eng_pop_i,
  output logic [7:0]        eng_rdata_o,
  input  logic              eng_done_i,
  input  logic [CNT_W-1:0]  thr_wr_i,
  input  logic [CNT_W-1:0]  thr_rd_i,
  input  logic [IRQ_N-1:0]  irq_en_i,
  input  logic [IRQ_N-1:0]  irq_clr_i,
  output logic [CNT_W-1:0]  fill_o,
  output logic [CNT_W-1:0]  free_o,
  output logic [IRQ_N-1:0]  irq_stat_o,
  output logic              irq_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH_BYTES);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH_BYTES);

  logic [CNT_W-1:0] cnt;
  logic [PTR_W-1:0] wp, rp;
  logic wr_word, wr_byte, ovf, udf;
  irq_vec_t set;

  wbf_ctrl #(
    .DEPTH_BYTES(DEPTH_BYTES), .WORD_BYTES(WORD_BYTES), .CNT_W(CNT_W), .PTR_W(PTR_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .sw_wr_i, .sw_rd_i, .eng_push_i, .eng_pop_i, .eng_done_i,
    .cnt_o(cnt), .wp_o(wp), .rp_o(rp), .wr_word_o(wr_word), .wr_byte_o(wr_byte),
    .ovf_o(ovf), .udf_o(udf)
  );

  wbf_store #(
    .DEPTH_BYTES(DEPTH_BYTES), .WORD_BYTES(WORD_BYTES), .CNT_W(CNT_W), .PTR_W(PTR_W),
    .WORD_W(WORD_W)
  ) u_store (
    .clk_i, .wr_word_i(wr_word), .wr_byte_i(wr_byte), .wp_i(wp), .rp_i(rp),
    .cnt_i(cnt), .word_i(sw_wdata_i), .byte_i(eng_wdata_i),
    .word_o(sw_rdata_o), .byte_o(eng_rdata_o)
  );

  assign set.wthr = cnt <= thr_wr_i;
  assign set.rthr = cnt >= thr_rd_i;
  assign set.ovf  = ovf;
  assign set.udf  = udf;

  wbf_irq u_irq (
    .clk_i, .rst_ni, .set_i(set), .clr_i(irq_clr_i), .en_i(irq_en_i),
    .stat_o(irq_stat_o), .irq_o
  );

  assign fill_o = cnt;
  assign free_o = DEPTH_C - cnt;

  p_pad_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done_i && cnt == CNT_W'(2)) |-> sw_rdata_o[WORD_W-1:16] == '0);
  p_empty_rd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_rd_i && cnt == '0) |=> irq_stat_o[IRQ_UDF]);
endmodule

// File: tb/tb_wordbyte_fifo.sv
`timescale 1ns/1ps
module tb_wordbyte_fifo;
  localparam int DEPTH = 128;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic sw_wr, sw_rd, eng_push, eng_pop, eng_done;
  logic [31:0] sw_wdata, sw_rdata;
  logic [7:0] eng_wdata, eng_rdata, thr_wr, thr_rd, fill, free;
  logic [3:0] irq_en, irq_clr, irq_stat;
  logic irq;

  wordbyte_fifo dut (
    .clk_i(clk), .rst_ni(rst_n), .sw_wr_i(sw_wr), .sw_wdata_i(sw_wdata),
    .sw_rd_i(sw_rd), .sw_rdata_o(sw_rdata), .eng_push_i(eng_push),
    .eng_wdata_i(eng_wdata), .eng_pop_i(eng_pop), .eng_rdata_o(eng_rdata),
    .eng_done_i(eng_done), .thr_wr_i(thr_wr), .thr_rd_i(thr_rd),
    .irq_en_i(irq_en), .irq_clr_i(irq_clr), .fill_o(fill), .free_o(free),
    .irq_stat_o(irq_stat), .irq_o(irq)
  );

  int vecs = 0, errs = 0;
  logic [7:0] q[$];
  logic [3:0] m_stat;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_word();
    logic [31:0] w = '0;
    for (int i = 0; i < 4; i++) if (i < q.size()) w[8*i +: 8] = q[i];
    return w;
  endfunction

  task automatic compare();
    chk("R2 fill", 32'(fill), 32'(q.size()));
    chk("R2 free", 32'(free), 32'(DEPTH - q.size()));
    if (q.size() > 0) chk("R3 eng_rdata", 32'(eng_rdata), 32'(q[0]));
    chk("R4 sw_rdata", sw_rdata, m_word());
    chk("R10 status", 32'(irq_stat), 32'(m_stat));
    chk("R11 irq", 32'(irq), 32'(|(m_stat & irq_en)));
  endtask

  // one clock: model update from current inputs, then compare after the edge
  task automatic step();
    int cnt = q.size();
    logic wr_ok, rd_ok, push_ok, pop_ok, oe, ue;
    logic [3:0] setv;
    wr_ok   = sw_wr && (DEPTH - cnt) >= 4;
    rd_ok   = sw_rd && (cnt >= 4 || (eng_done && cnt > 0));
    push_ok = eng_push && !sw_wr && cnt < DEPTH;
    pop_ok  = eng_pop && !sw_rd && cnt > 0;
    oe = sw_wr && !wr_ok;
    ue = sw_rd && !rd_ok;
    setv = {ue, oe, 1'(cnt >= int'(thr_rd)), 1'(cnt <= int'(thr_wr))};
    m_stat = (m_stat & ~irq_clr) | setv;
    if (rd_ok) repeat ((cnt >= 4) ? 4 : cnt) void'(q.pop_front());
    if (pop_ok) void'(q.pop_front());
    if (wr_ok) for (int i = 0; i < 4; i++) q.push_back(sw_wdata[8*i +: 8]);
    if (push_ok) q.push_back(eng_wdata);
    @(negedge clk);
    compare();
    sw_wr = 0; sw_rd = 0; eng_push = 0; eng_pop = 0; irq_clr = '0;
  endtask

  task automatic wr_word(logic [31:0] w);
    sw_wr = 1; sw_wdata = w; step();
  endtask
  task automatic push_byte(logic [7:0] b);
    eng_push = 1; eng_wdata = b; step();
  endtask
  task automatic drain();
    eng_done = 1;
    while (fill != 0) begin sw_rd = 1; step(); end
    eng_done = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL R1 watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; sw_wr = 0; sw_rd = 0; eng_push = 0; eng_pop = 0; eng_done = 0;
    sw_wdata = '0; eng_wdata = '0; thr_wr = 8'd0; thr_rd = 8'd128;
    irq_en = 4'hF; irq_clr = '0; m_stat = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 fill", 32'(fill), 0);
    chk("R1 free", 32'(free), 128);
    chk("R1 status", 32'(irq_stat), 0);
    chk("R1 irq", 32'(irq), 0);
    rst_n = 1;
    step();

    // R3 word write, bytes leave least-significant first
    wr_word(32'h44332211);
    wr_word(32'h88776655);
    chk("R3 first byte", 32'(eng_rdata), 32'h11);
    for (int i = 0; i < 8; i++) begin eng_pop = 1; step(); end
    chk("R3 emptied", 32'(fill), 0);

    // R4 engine bytes read as a word
    for (int i = 0; i < 6; i++) push_byte(8'hA0 + 8'(i));
    chk("R4 word", sw_rdata, 32'hA3A2A1A0);
    sw_rd = 1; step();
    chk("R4 after read", 32'(fill), 2);
    // R6 partial read without end of transfer
    irq_clr = 4'hF; step();
    sw_rd = 1; step();
    chk("R6 ignored", 32'(fill), 2);
    chk("R6 underflow bit", 32'(irq_stat[3]), 1);
    // R7 padded last word
    eng_done = 1; step();
    chk("R7 padded", sw_rdata, 32'h0000A5A4);
    sw_rd = 1; step();
    chk("R7 emptied", 32'(fill), 0);
    eng_done = 0;
    // R6 read on empty even with done
    eng_done = 1; irq_clr = 4'h8; step();
    sw_rd = 1; step();
    chk("R6 empty underflow", 32'(irq_stat[3]), 1);
    eng_done = 0;

    // R5 fill to the top then overflow
    for (int i = 0; i < 32; i++) wr_word(32'hC0DE0000 + 32'(i));
    chk("R5 full", 32'(free), 0);
    irq_clr = 4'h4; step();
    wr_word(32'hDEADBEEF);
    chk("R5 ignored", 32'(fill), 128);
    chk("R5 overflow bit", 32'(irq_stat[2]), 1);
    push_byte(8'h5A);
    chk("R12 push when full", 32'(fill), 128);
    drain();

    // R12 software request drops engine access
    sw_wr = 1; sw_wdata = 32'h0D0C0B0A; eng_push = 1; eng_wdata = 8'hEE; step();
    chk("R12 push dropped", 32'(fill), 4);
    sw_rd = 1; eng_pop = 1; step();
    chk("R12 pop dropped", 32'(fill), 0);

    // R8..R11 thresholds, sticky clear, enables
    thr_wr = 8'd8; thr_rd = 8'd128; step();
    chk("R8 wthr set", 32'(irq_stat[0]), 1);
    for (int i = 0; i < 3; i++) wr_word(32'h01020304);
    irq_clr = 4'h1; step();
    step();
    chk("R10 cleared", 32'(irq_stat[0]), 0);
    thr_wr = 8'd12; step();
    chk("R8 equal", 32'(irq_stat[0]), 1);
    thr_rd = 8'd12; step();
    chk("R9 rthr set", 32'(irq_stat[1]), 1);
    irq_clr = 4'h2; step();
    chk("R10 set wins", 32'(irq_stat[1]), 1);
    irq_en = 4'h0; step();
    chk("R11 masked", 32'(irq), 0);
    irq_en = 4'h2; step();
    chk("R11 enabled", 32'(irq), 1);
    thr_rd = 8'd128; thr_wr = 8'd0;
    drain();

    // random traffic, fill phase then drain phase
    for (int c = 0; c < 4000; c++) begin
      int r = int'($urandom_range(0, 99));
      bit fillp = (c / 500) % 2 == 0;
      sw_wr    = fillp ? (r < 35) : (r < 10);
      sw_rd    = fillp ? (r >= 90) : (r >= 65);
      eng_push = fillp ? ($urandom_range(0, 99) < 40) : ($urandom_range(0, 99) < 10);
      eng_pop  = fillp ? ($urandom_range(0, 99) < 10) : ($urandom_range(0, 99) < 40);
      sw_wdata = $urandom;
      eng_wdata = 8'($urandom);
      eng_done = $urandom_range(0, 7) == 0;
      irq_clr  = 4'($urandom);
      if ($urandom_range(0, 31) == 0) begin
        thr_wr = 8'($urandom_range(0, 128));
        thr_rd = 8'($urandom_range(0, 128));
        irq_en = 4'($urandom);
      end
      step();
    end

    finish_run();
  end
endmodule